// File: doc/BRIEF.md
# Serial Register Port

This block is a serial control port in front of a small bank of 8-bit mode registers. A host selects the port with an active-low select line, toggles a serial clock, and moves one access per selection: an instruction byte that holds a read/write flag and a 5-bit register address, and then exactly one data byte. Input bits are taken on rising serial-clock edges. Read data leaves on falling edges.

Register 0 configures the port itself. One bit there reverses the bit order of both bytes. Another bit moves read data from the dedicated output pin onto the shared data pin, which gives 3-wire operation. A third bit, when written as 1, returns every other register to its default. The whole bank is also presented as a flat vector, so the surrounding logic can decode its fields. All serial pins are oversampled by the system clock, so the block has a single clock domain.

Top module: `spi_ctrl_port`

## Requirements
- R1: Reset (`rst` high at a `clk` edge) loads register 0 with 00h and each register n ≥ 1 with (37·n + 3) mod 256. Neither output enable is active after reset.
- R2: An access is 16 serial bits, sampled on `sclk` rising edges while `cs_n` is low. In MSB-first order the instruction byte is sent bit 7 first. Its bit 7 is the flag (0 write, 1 read), bits 6:5 are ignored and bits 4:0 are the address. The data byte follows, most significant bit first.
- R3: With register 0 bit 7 = 0 (4-wire), read data goes out on `sdo` with `sdo_oe` high and `sdio_oe` low. A new bit is launched on each `sclk` falling edge, starting with the fall after the 8th rising edge.
- R4: With register 0 bit 7 = 1 (3-wire), read data goes out on `sdio_o` with `sdio_oe` high and `sdo_oe` low. The two enables are never high together.
- R5: With register 0 bit 6 = 1, both bytes travel least significant bit first. The instruction byte then has the flag in bit 0 and the address in bits 5:1, with address bit 0 in bit 1.
- R6: Writing register 0 with bit 5 = 1 returns registers 1 and up to their defaults. Register 0 takes the written bits 7:6 and 4:0. Register 0 bit 5 always reads 0.
- R7: If `cs_n` rises before the 16th rising edge, the access is dropped and no register changes. The next low period starts a new instruction byte.
- R8: A write to an address at or above the register count changes nothing. A read from such an address returns 00h.
- R9: Further `sclk` cycles after the 16th bit, with `cs_n` still low, cause no second access.
- R10: `cfg_regs[8n+7:8n]` holds register n. A write shows there two `clk` cycles after the `sclk` rise that carries its last data bit. It changes only through a write or a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst | input | 1 | Synchronous active-high hardware reset |
| cs_n | input | 1 | Active-low select; high clears the port state |
| sclk | input | 1 | Serial clock |
| sdio_i | input | 1 | Serial data in on the shared pin |
| sdio_o | output | 1 | Read data on the shared pin (3-wire) |
| sdio_oe | output | 1 | Drive enable for the shared pin |
| sdo | output | 1 | Read data on the dedicated pin (4-wire) |
| sdo_oe | output | 1 | Drive enable for the dedicated pin |
| cfg_regs | output | 8·NUM_REGS | Flattened register bank, register n at byte n |

## Verification
Every serial pin passes through one register stage, and edges are found one stage later. A sampled bit, a committed write and a launched read bit therefore appear two `clk` cycles after the `sclk` edge that causes them. The bench holds each `sclk` phase for four `clk` cycles. It reads the output pin at the end of the low phase, two cycles after the launch has settled and before the next rise. It compares `cfg_regs` with its model only after `cs_n` has returned high.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

    localparam int BYTE_W    = 8;
    localparam int ADDR_W    = 5;
    localparam int BIT_BIDIR = 7;
    localparam int BIT_LSB   = 6;
    localparam int BIT_SRST  = 5;

    typedef enum logic [1:0] {
        PH_INSTR = 2'd0,
        PH_DATA  = 2'd1,
        PH_DONE  = 2'd2
    } phase_e;

    typedef struct packed {
        logic              rd;
        logic [ADDR_W-1:0] addr;
    } instr_t;

    function automatic logic [BYTE_W-1:0] bit_rev(input logic [BYTE_W-1:0] v);
        logic [BYTE_W-1:0] r;
        for (int k = 0; k < BYTE_W; k++) r[k] = v[BYTE_W-1-k];
        return r;
    endfunction

    // arrived[7] is the first bit on the wire
    function automatic instr_t decode_instr(input logic [BYTE_W-1:0] arrived,
                                            input logic lsb_first);
        instr_t t;
        logic [BYTE_W-1:0] r;
        r = bit_rev(arrived);
        if (lsb_first) begin
            t.rd   = r[0];
            t.addr = r[ADDR_W:1];
        end else begin
            t.rd   = arrived[BYTE_W-1];
            t.addr = arrived[ADDR_W-1:0];
        end
        return t;
    endfunction

    function automatic logic [BYTE_W-1:0] reg_default(input int idx);
        if (idx == 0) return '0;
        return BYTE_W'((idx * 37 + 3) % 256);
    endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync (
    input  logic clk,
    input  logic rst,
    input  logic sclk,
    input  logic cs_n,
    input  logic sdi,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic sel,
    output logic sdi_s
);
    logic sclk_q;
    logic sclk_d;
    logic cs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= 1'b0;
            sclk_d <= 1'b0;
            cs_q   <= 1'b1;
            sdi_s  <= 1'b0;
        end else begin
            sclk_q <= sclk;
            sclk_d <= sclk_q;
            cs_q   <= cs_n;
            sdi_s  <= sdi;
        end
    end

    assign sel       = ~cs_q;
    assign sclk_rise = sel &  sclk_q & ~sclk_d;
    assign sclk_fall = sel & ~sclk_q &  sclk_d;
endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
    import spi_port_pkg::*;
#(
    parameter int NUM_REGS = 10
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               sclk_rise,
    input  logic                               sclk_fall,
    input  logic                               sel,
    input  logic                               sdi,
    input  logic                               lsb_first,
    input  logic [NUM_REGS-1:0][BYTE_W-1:0]    regs,
    output logic                               wr_en,
    output logic [ADDR_W-1:0]                  wr_addr,
    output logic [BYTE_W-1:0]                  wr_data,
    output logic                               tx_bit,
    output logic                               tx_en
);
    localparam int CNT_W = $clog2(BYTE_W);

    phase_e            phase;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] arr;
    logic [BYTE_W-1:0] tx_sh;
    logic              rd_q;
    logic [BYTE_W-1:0] arr_nx;
    logic [BYTE_W-1:0] rd_val;
    instr_t            ins;
    logic              last_bit;

    assign arr_nx   = {arr[BYTE_W-2:0], sdi};
    assign last_bit = (cnt == CNT_W'(BYTE_W - 1));

    always_comb begin
        ins    = decode_instr(arr_nx, lsb_first);
        rd_val = '0;
        for (int k = 0; k < NUM_REGS; k++) begin
            if (ins.addr == ADDR_W'(k)) rd_val = regs[k];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_INSTR;
            cnt     <= '0;
            arr     <= '0;
            tx_sh   <= '0;
            rd_q    <= 1'b0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
            tx_bit  <= 1'b0;
            tx_en   <= 1'b0;
        end else if (!sel) begin
            phase <= PH_INSTR;
            cnt   <= '0;
            rd_q  <= 1'b0;
            wr_en <= 1'b0;
            tx_en <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            if (sclk_rise) begin
                arr <= arr_nx;
                unique case (phase)
                    PH_INSTR: begin
                        cnt <= cnt + 1'b1;
                        if (last_bit) begin
                            phase   <= PH_DATA;
                            rd_q    <= ins.rd;
                            wr_addr <= ins.addr;
                            tx_sh   <= lsb_first ? bit_rev(rd_val) : rd_val;
                        end
                    end
                    PH_DATA: begin
                        cnt <= cnt + 1'b1;
                        if (last_bit) begin
                            phase <= PH_DONE;
                            if (!rd_q) begin
                                wr_en   <= 1'b1;
                                wr_data <= lsb_first ? bit_rev(arr_nx) : arr_nx;
                            end
                        end
                    end
                    default: ;
                endcase
            end
            if (sclk_fall && phase == PH_DATA && rd_q) begin
                tx_bit <= tx_sh[BYTE_W-1];
                tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
                tx_en  <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
    import spi_port_pkg::*;
#(
    parameter int NUM_REGS = 10
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            wr_en,
    input  logic [ADDR_W-1:0]               wr_addr,
    input  logic [BYTE_W-1:0]               wr_data,
    output logic [NUM_REGS-1:0][BYTE_W-1:0] regs,
    output logic                            lsb_first,
    output logic                            bidir
);
    localparam logic [BYTE_W-1:0] KEEP0 = ~(BYTE_W'(1) << BIT_SRST);

    logic soft_clr;
    assign soft_clr = wr_en && (wr_addr == '0) && wr_data[BIT_SRST];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < NUM_REGS; k++) regs[k] <= reg_default(k);
        end else if (wr_en) begin
            for (int k = 0; k < NUM_REGS; k++) begin
                if (k == 0) begin
                    if (wr_addr == '0) regs[0] <= wr_data & KEEP0;
                end else if (soft_clr) begin
                    regs[k] <= reg_default(k);
                end else if (wr_addr == ADDR_W'(k)) begin
                    regs[k] <= wr_data;
                end
            end
        end
    end

    assign lsb_first = regs[0][BIT_LSB];
    assign bidir     = regs[0][BIT_BIDIR];
endmodule

// File: rtl/spi_ctrl_port.sv
module spi_ctrl_port
    import spi_port_pkg::*;
#(
    parameter int NUM_REGS = 10
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         cs_n,
    input  logic                         sclk,
    input  logic                         sdio_i,
    output logic                         sdio_o,
    output logic                         sdio_oe,
    output logic                         sdo,
    output logic                         sdo_oe,
    output logic [NUM_REGS*BYTE_W-1:0]   cfg_regs
);
    logic                            sclk_rise;
    logic                            sclk_fall;
    logic                            sel;
    logic                            sdi_s;
    logic                            lsb_first;
    logic                            bidir;
    logic                            wr_en;
    logic [ADDR_W-1:0]               wr_addr;
    logic [BYTE_W-1:0]               wr_data;
    logic                            tx_bit;
    logic                            tx_en;
    logic [NUM_REGS-1:0][BYTE_W-1:0] regs;

    spi_pin_sync u_sync (
        .clk       (clk),
        .rst       (rst),
        .sclk      (sclk),
        .cs_n      (cs_n),
        .sdi       (sdio_i),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .sel       (sel),
        .sdi_s     (sdi_s)
    );

    spi_xfer_engine #(.NUM_REGS(NUM_REGS)) u_xfer (
        .clk       (clk),
        .rst       (rst),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .sel       (sel),
        .sdi       (sdi_s),
        .lsb_first (lsb_first),
        .regs      (regs),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .tx_bit    (tx_bit),
        .tx_en     (tx_en)
    );

    spi_reg_bank #(.NUM_REGS(NUM_REGS)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .regs      (regs),
        .lsb_first (lsb_first),
        .bidir     (bidir)
    );

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
        assign cfg_regs[g*BYTE_W +: BYTE_W] = regs[g];
    end

    assign sdio_o  = tx_bit;
    assign sdo     = tx_bit;
    assign sdio_oe = tx_en &  bidir;
    assign sdo_oe  = tx_en & ~bidir;
endmodule

// File: rtl/spi_ctrl_port_chk.sv
module spi_ctrl_port_chk
    import spi_port_pkg::*;
#(
    parameter int NUM_REGS = 10
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       cs_n,
    input logic                       sdio_oe,
    input logic                       sdo_oe,
    input logic [NUM_REGS*BYTE_W-1:0] cfg_regs,
    input logic                       wr_en,
    input logic [ADDR_W-1:0]          wr_addr,
    input logic [BYTE_W-1:0]          wr_data
);
    localparam int FLAT_W = NUM_REGS * BYTE_W;

    logic [FLAT_W-1:0] dflt;
    always_comb begin
        for (int k = 0; k < NUM_REGS; k++) dflt[k*BYTE_W +: BYTE_W] = reg_default(k);
    end

    a_r1_reset_defaults: assert property (@(posedge clk)
        rst |=> (cfg_regs == dflt));

    a_r4_single_driver: assert property (@(posedge clk) disable iff (rst)
        !(sdio_oe && sdo_oe));

    a_r4_shared_pin_needs_mode: assert property (@(posedge clk) disable iff (rst)
        sdio_oe |-> cfg_regs[BIT_BIDIR]);

    a_r7_deselect_releases: assert property (@(posedge clk) disable iff (rst)
        (cs_n && $past(cs_n)) |=> !(sdio_oe || sdo_oe));

    a_r10_hold_without_write: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(cfg_regs));

    a_r8_high_addr_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr_en && int'(wr_addr) >= NUM_REGS) |=> $stable(cfg_regs));

    a_r6_soft_clear: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == '0 && wr_data[BIT_SRST])
        |=> (cfg_regs[FLAT_W-1:BYTE_W] == dflt[FLAT_W-1:BYTE_W]) && !cfg_regs[BIT_SRST]);
endmodule

bind spi_ctrl_port spi_ctrl_port_chk #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cs_n     (cs_n),
    .sdio_oe  (sdio_oe),
    .sdo_oe   (sdo_oe),
    .cfg_regs (cfg_regs),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data)
);

// File: tb/test_spi_ctrl_port.sv
`timescale 1ns/1ps
module test_spi_ctrl_port;
    localparam int NR = 10;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            cs_n = 1'b1;
    logic            sclk = 1'b0;
    logic            sdio_i = 1'b0;
    logic            sdio_o, sdio_oe, sdo, sdo_oe;
    logic [NR*8-1:0] cfg_regs;

    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 0;
    logic [7:0] mdl [NR];

    always #10 clk = ~clk;

    spi_ctrl_port #(.NUM_REGS(NR)) i_spi_ctrl_port (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdio_i(sdio_i),
        .sdio_o(sdio_o), .sdio_oe(sdio_oe), .sdo(sdo), .sdo_oe(sdo_oe),
        .cfg_regs(cfg_regs)
    );

    function automatic logic [7:0] dflt(input int n);
        return (n == 0) ? 8'h00 : 8'((37 * n + 3) % 256);
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int k = 0; k < NR; k++) mdl[k] = dflt(k);
    endtask

    task automatic model_write(input int a, input logic [7:0] d);
        if (a == 0) begin
            mdl[0] = d & 8'hDF;
            if (d[5]) for (int k = 1; k < NR; k++) mdl[k] = dflt(k);
        end else if (a < NR) begin
            mdl[a] = d;
        end
    endtask

    task automatic check_regs(input string tag);
        for (int k = 0; k < NR; k++) chk(tag, 32'(cfg_regs[k*8 +: 8]), 32'(mdl[k]));
    endtask

    // one access; nbits < 16 aborts, > 16 adds idle clocks
    task automatic xfer(input bit rd, input int a, input logic [7:0] d,
                        input int nbits, output logic [7:0] rdata, input string tag);
        logic [7:0] ib;
        logic [15:0] seq;
        bit lsb, bid;
        lsb = mdl[0][6];
        bid = mdl[0][7];
        rdata = 8'h00;
        ib = lsb ? {2'b00, 5'(a), rd} : {rd, 2'b00, 5'(a)};
        for (int i = 0; i < 8; i++) begin
            seq[15-i]  = lsb ? ib[i] : ib[7-i];
            seq[7-i]   = lsb ? d[i]  : d[7-i];
        end
        cs_n = 1'b0;
        tick(4);
        for (int i = 0; i < nbits; i++) begin
            sdio_i = (i < 16) ? seq[15-i] : 1'b1;
            tick(4);
            if (rd && i >= 8 && i < 16) begin
                if (i == 8) begin
                    chk({tag, " oe shared"}, 32'(sdio_oe), 32'(bid));
                    chk({tag, " oe dedicated"}, 32'(sdo_oe), 32'(!bid));
                end
                if (lsb) rdata[i-8]  = bid ? sdio_o : sdo;
                else     rdata[15-i] = bid ? sdio_o : sdo;
            end
            sclk = 1'b1;
            tick(4);
            sclk = 1'b0;
        end
        tick(4);
        cs_n = 1'b1;
        tick(4);
        if (!rd && nbits >= 16) model_write(a, d);
    endtask

    task automatic do_read(input int a, input string tag);
        logic [7:0] r;
        xfer(1'b1, a, 8'h00, 16, r, tag);
        chk(tag, 32'(r), 32'((a < NR) ? mdl[a] : 8'h00));
    endtask

    task automatic do_write(input int a, input logic [7:0] d, input string tag);
        logic [7:0] r;
        xfer(1'b0, a, d, 16, r, tag);
        check_regs(tag);
    endtask

    initial begin
        logic [7:0] r;
        void'($urandom(32'd20240611));
        model_reset();
        tick(5);
        rst = 1'b0;
        tick(2);
        // R1 reset state
        check_regs("R1 reset values");
        chk("R1 sdo_oe idle", 32'(sdo_oe), 0);
        chk("R1 sdio_oe idle", 32'(sdio_oe), 0);

        // R2 / R3 / R10 MSB-first write and 4-wire read
        do_write(3, 8'hA5, "R2 R10 write reg3");
        do_read(3, "R3 read reg3");
        do_read(9, "R3 read reg9 default");

        // R7 aborted write
        xfer(1'b0, 4, 8'h3C, 12, r, "R7 abort");
        check_regs("R7 abort no change");
        xfer(1'b0, 4, 8'h3C, 3, r, "R7 abort in instr");
        check_regs("R7 abort short");
        do_write(4, 8'h3C, "R7 next access ok");

        // R8 out of range
        do_write(20, 8'hFF, "R8 high write ignored");
        do_read(20, "R8 high read zero");
        do_read(10, "R8 read one past end");

        // R9 extra clocks
        xfer(1'b0, 2, 8'h81, 24, r, "R9 extra");
        check_regs("R9 single access");

        // R4 3-wire
        do_write(0, 8'h80, "R4 enter 3-wire");
        do_read(3, "R4 read on shared pin");

        // R5 LSB-first
        do_write(0, 8'h40, "R5 enter lsb first");
        do_write(6, 8'h1E, "R5 lsb write");
        do_read(6, "R5 lsb read");
        do_write(17, 8'h55, "R5 lsb high addr");

        // R6 soft reset, in lsb order
        do_write(0, 8'hE3, "R6 soft reset");
        chk("R6 bit5 reads zero", 32'(cfg_regs[5]), 0);
        do_read(0, "R6 R4 R5 read reg0");

        // R1 hardware reset also clears reg0
        tick(1);
        rst = 1'b1;
        tick(3);
        rst = 1'b0;
        model_reset();
        tick(2);
        check_regs("R1 hw reset");

        // random mix
        for (int it = 0; it < 80; it++) begin
            int sel_op;
            int a;
            logic [7:0] d;
            sel_op = int'($urandom % 8);
            a = int'($urandom % 12);
            d = 8'($urandom);
            if (sel_op == 0) begin
                d[5] = ($urandom % 4 == 0);
                do_write(0, d, "R6 R5 random reg0");
            end else if (sel_op < 4) begin
                do_write((a == 0) ? 1 : a, d, "R2 R8 random write");
            end else if (sel_op < 7) begin
                do_read(a, "R3 R4 random read");
            end else begin
                xfer(1'b0, (a == 0) ? 1 : a, d, 1 + int'($urandom % 15), r, "R7 rnd");
                check_regs("R7 random abort");
            end
        end

        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule